// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside a small 8-bit CPU core. It decides at each instruction boundary whether the core must take an interrupt, and it then steps the entry and return sequences. Maskable requests come in as a pending vector and are gated by the core's global mask bit. A software trap strobe is latched and taken at the next boundary, whatever the mask says. When several sources compete, a fixed priority picks one. The trap ranks above every maskable source, and among the maskable sources the lowest index wins.

On entry the sequencer sends five one-cycle save commands to a valid/ready stack port, one per context byte. It then presents the selected vector address for one cycle, together with a write of the mask bit to 1. It also acknowledges the source, so that an edge-latched request can be cleared. A return strobe runs the five restore commands in reverse order and then writes the mask bit to 0. Two registered wake outputs tell the power controller when to leave Wait mode (any pending source) and when to leave Halt mode (only sources flagged as Halt-capable).

Top module: `intr_sequencer`

## Requirements
- R1: While `i_bit` is 1, a pending maskable request starts no entry, even across several instruction boundaries. The request is taken at the first boundary after `i_bit` returns to 0.
- R2: An entry begins only when `instr_end` is 1 in an idle cycle and some source is eligible. `stk_valid` rises in the following cycle.
- R3: Entry issues save commands with `stk_push`=1 in the code order 0 (PC low), 1 (PC high), 2 (X), 3 (A), 4 (CC). Each command holds `stk_reg` and `stk_push` stable until `stk_ready` is 1.
- R4: In the cycle after the CC save is accepted, `vec_valid` is 1 for exactly one cycle, with `vec_addr` = `VEC_TABLE[id]`. Here id 0 is the trap and id k+1 is maskable source k. In the same cycle `mask_wr`=1 and `mask_val`=1.
- R5: A `trap_req` pulse is remembered until the next `instr_end`. It is taken there even when `i_bit` is 1, and it takes precedence over any maskable source pending at the same boundary.
- R6: Among pending maskable sources, the one with the lowest index is served first. The others stay pending.
- R7: A `trap_req` pulse that arrives while a sequence is running is not lost. It is taken at the first `instr_end` after the block returns to idle.
- R8: An `iret_req` in an idle cycle issues restore commands with `stk_push`=0 in the code order 4, 3, 2, 1, 0.
- R9: In the cycle after the code-0 restore is accepted, `mask_wr`=1 and `mask_val`=0.
- R10: `ack_valid` is 1, with `ack_id` = source index + 1, in the vector cycle of a maskable entry. It stays 0 in the vector cycle of a trap entry.
- R11: `wake_wait` is 1 one cycle after any `irq_pend` bit is 1, whatever `i_bit` is. `wake_halt` is 1 only when a pending bit is also set in `HALT_MASK`.
- R12: After reset, `stk_valid`, `vec_valid`, `mask_wr`, `ack_valid`, `busy` and both wake outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pend | input | NUM_SRC | Pending maskable requests, bit k = source k |
| trap_req | input | 1 | Software trap strobe |
| instr_end | input | 1 | Current instruction finishes this cycle |
| iret_req | input | 1 | Return-from-interrupt strobe |
| i_bit | input | 1 | Current global mask bit |
| stk_valid | output | 1 | Stack command valid |
| stk_push | output | 1 | 1 = save, 0 = restore |
| stk_reg | output | 3 | Context byte code (0 PCL, 1 PCH, 2 X, 3 A, 4 CC) |
| stk_ready | input | 1 | Stack accepts the command |
| vec_valid | output | 1 | Load `vec_addr` into the PC |
| vec_addr | output | 16 | Service routine address |
| mask_wr | output | 1 | Write `mask_val` into the mask bit |
| mask_val | output | 1 | New mask bit value |
| ack_valid | output | 1 | Maskable source accepted |
| ack_id | output | IDW | Accepted id (source index + 1) |
| busy | output | 1 | Sequence in progress |
| wake_wait | output | 1 | Leave Wait mode |
| wake_halt | output | 1 | Leave Halt mode |

## Verification
A wrong step counter or state value shows on the very next accepted stack transfer, as a byte code out of order or a push/pop direction that does not match. A wrongly latched id shows one cycle after the CC save, as a wrong vector address or a wrong acknowledge. A lost trap latch or a faulty mask gate shows at the next instruction boundary: either an entry starts when none should, or no entry starts when one should. The scoreboard pairs each stack handshake and each vector or return cycle with the item it expects, so it catches these faults at the cycle where they first appear.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

  localparam int unsigned CTX_BYTES = 5;
  localparam logic [2:0]  CTX_LAST  = 3'(CTX_BYTES - 1);

  typedef enum logic [2:0] {
    RG_PCL = 3'd0,
    RG_PCH = 3'd1,
    RG_X   = 3'd2,
    RG_A   = 3'd3,
    RG_CC  = 3'd4
  } ctx_reg_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SAVE,
    ST_VEC,
    ST_RESTORE,
    ST_RET
  } seq_state_e;

endpackage

// File: rtl/intr_prio_pick.sv
module intr_prio_pick #(
  parameter int unsigned N   = 4,
  parameter int unsigned IDW = 3
) (
  input  logic [N-1:0]   req,
  input  logic           mask,
  input  logic           trap,
  output logic           take,
  output logic [IDW-1:0] id
);
  // id 0 = trap, id k+1 = source k; lower id wins
  always_comb begin
    take = 1'b0;
    id   = '0;
    if (trap) begin
      take = 1'b1;
    end else if (!mask) begin
      for (int k = N - 1; k >= 0; k--) begin
        if (req[k]) begin
          take = 1'b1;
          id   = IDW'(k + 1);
        end
      end
    end
  end
endmodule

// File: rtl/intr_vec_reg.sv
module intr_vec_reg #(
  parameter int unsigned       N     = 4,
  parameter int unsigned       IDW   = 3,
  parameter logic [N:0][15:0]  TABLE = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [IDW-1:0] id,
  output logic [15:0]    addr
);
  logic [15:0] lookup;

  always_comb begin
    lookup = '0;
    for (int k = 0; k <= N; k++) begin
      if (id == IDW'(k)) lookup = TABLE[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       addr <= '0;
    else if (load) addr <= lookup;
  end
endmodule

// File: rtl/intr_wake_gen.sv
module intr_wake_gen #(
  parameter int unsigned  N         = 4,
  parameter logic [N-1:0] HALT_MASK = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic         wake_wait,
  output logic         wake_halt
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wake_wait <= 1'b0;
      wake_halt <= 1'b0;
    end else begin
      wake_wait <= |req;
      wake_halt <= |(req & HALT_MASK);
    end
  end
endmodule

// File: rtl/intr_sequencer.sv
module intr_sequencer
  import intr_seq_pkg::*;
#(
  parameter int unsigned              NUM_SRC   = 4,
  parameter int unsigned              IDW       = $clog2(NUM_SRC + 1),
  parameter logic [NUM_SRC:0][15:0]   VEC_TABLE = {16'hFFF4, 16'hFFF6, 16'hFFF8, 16'hFFFA, 16'hFFFC},
  parameter logic [NUM_SRC-1:0]       HALT_MASK = 4'b0001
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_pend,
  input  logic               trap_req,
  input  logic               instr_end,
  input  logic               iret_req,
  input  logic               i_bit,
  output logic               stk_valid,
  output logic               stk_push,
  output logic [2:0]         stk_reg,
  input  logic               stk_ready,
  output logic               vec_valid,
  output logic [15:0]        vec_addr,
  output logic               mask_wr,
  output logic               mask_val,
  output logic               ack_valid,
  output logic [IDW-1:0]     ack_id,
  output logic               busy,
  output logic               wake_wait,
  output logic               wake_halt
);

  seq_state_e     state;
  logic [2:0]     step;
  logic [IDW-1:0] sel_id;
  logic           trap_pend;
  logic           trap_eff;
  logic           pick_take;
  logic [IDW-1:0] pick_id;
  logic           start_entry;
  logic           start_return;
  logic           xfer;

  assign trap_eff     = trap_pend | trap_req;
  assign start_return = (state == ST_IDLE) && iret_req;
  assign start_entry  = (state == ST_IDLE) && !iret_req && instr_end && pick_take;
  assign xfer         = stk_valid && stk_ready;

  intr_prio_pick #(.N(NUM_SRC), .IDW(IDW)) u_pick (
    .req  (irq_pend),
    .mask (i_bit),
    .trap (trap_eff),
    .take (pick_take),
    .id   (pick_id)
  );

  intr_vec_reg #(.N(NUM_SRC), .IDW(IDW), .TABLE(VEC_TABLE)) u_vec (
    .clk  (clk),
    .rst  (rst),
    .load (start_entry),
    .id   (pick_id),
    .addr (vec_addr)
  );

  intr_wake_gen #(.N(NUM_SRC), .HALT_MASK(HALT_MASK)) u_wake (
    .clk       (clk),
    .rst       (rst),
    .req       (irq_pend),
    .wake_wait (wake_wait),
    .wake_halt (wake_halt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      step      <= '0;
      sel_id    <= '0;
      trap_pend <= 1'b0;
    end else begin
      trap_pend <= trap_eff && !(start_entry && pick_id == '0);
      unique case (state)
        ST_IDLE: begin
          if (start_return) begin
            state <= ST_RESTORE;
            step  <= '0;
          end else if (start_entry) begin
            state  <= ST_SAVE;
            step   <= '0;
            sel_id <= pick_id;
          end
        end
        ST_SAVE: begin
          if (xfer) begin
            if (step == CTX_LAST) state <= ST_VEC;
            else                  step  <= step + 3'd1;
          end
        end
        ST_VEC:  state <= ST_IDLE;
        ST_RESTORE: begin
          if (xfer) begin
            if (step == CTX_LAST) state <= ST_RET;
            else                  step  <= step + 3'd1;
          end
        end
        ST_RET:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign stk_valid = (state == ST_SAVE) || (state == ST_RESTORE);
  assign stk_push  = (state == ST_SAVE);
  assign stk_reg   = (state == ST_RESTORE) ? (CTX_LAST - step) : step;
  assign vec_valid = (state == ST_VEC);
  assign mask_wr   = (state == ST_VEC) || (state == ST_RET);
  assign mask_val  = (state == ST_VEC);
  assign ack_valid = (state == ST_VEC) && (sel_id != '0);
  assign ack_id    = sel_id;
  assign busy      = (state != ST_IDLE);

endmodule

// File: rtl/intr_sequencer_chk.sv
module intr_sequencer_chk #(
  parameter int unsigned IDW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           instr_end,
  input logic           iret_req,
  input logic           stk_valid,
  input logic           stk_push,
  input logic [2:0]     stk_reg,
  input logic           stk_ready,
  input logic           vec_valid,
  input logic           mask_wr,
  input logic           mask_val,
  input logic           wake_wait,
  input logic           wake_halt
);
  AST_SAVE_STARTS_PCL: assert property (@(posedge clk) disable iff (rst)
    ($rose(stk_valid) && stk_push) |-> (stk_reg == 3'd0)); // R3
  AST_SAVE_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (stk_valid && stk_ready && stk_push && stk_reg != 3'd4) |=>
      (stk_valid && stk_push && stk_reg == $past(stk_reg) + 3'd1)); // R3
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (rst)
    (stk_valid && !stk_ready) |=> (stk_valid && $stable(stk_reg) && $stable(stk_push))); // R3
  AST_START_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    $rose(stk_valid) |-> $past(instr_end || iret_req)); // R2
  AST_VEC_AFTER_CC: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> ($past(stk_valid && stk_ready && stk_push && stk_reg == 3'd4)
                   && mask_wr && mask_val)); // R4
  AST_RESTORE_STARTS_CC: assert property (@(posedge clk) disable iff (rst)
    ($rose(stk_valid) && !stk_push) |-> (stk_reg == 3'd4)); // R8
  AST_RESTORE_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (stk_valid && stk_ready && !stk_push && stk_reg != 3'd0) |=>
      (stk_valid && !stk_push && stk_reg == $past(stk_reg) - 3'd1)); // R8
  AST_UNMASK_AFTER_PCL: assert property (@(posedge clk) disable iff (rst)
    (mask_wr && !mask_val) |-> $past(stk_valid && stk_ready && !stk_push && stk_reg == 3'd0)); // R9
  AST_HALT_IMPLIES_WAIT: assert property (@(posedge clk) disable iff (rst)
    wake_halt |-> wake_wait); // R11
endmodule

bind intr_sequencer intr_sequencer_chk #(.IDW(IDW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .instr_end (instr_end),
  .iret_req  (iret_req),
  .stk_valid (stk_valid),
  .stk_push  (stk_push),
  .stk_reg   (stk_reg),
  .stk_ready (stk_ready),
  .vec_valid (vec_valid),
  .mask_wr   (mask_wr),
  .mask_val  (mask_val),
  .wake_wait (wake_wait),
  .wake_halt (wake_halt)
);

// File: tb/intr_sequencer_bench.sv
module intr_sequencer_bench;
  localparam int NSRC = 4;
  localparam int IDW  = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] irq_pend = '0;
  logic            trap_req = 1'b0, instr_end = 1'b0, iret_req = 1'b0;
  logic            i_bit = 1'b0;
  logic            stk_valid, stk_push, stk_ready = 1'b0;
  logic [2:0]      stk_reg;
  logic            vec_valid, mask_wr, mask_val, ack_valid, busy, wake_wait, wake_halt;
  logic [15:0]     vec_addr;
  logic [IDW-1:0]  ack_id;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  typedef struct { int kind; int val; int id; string req; } item_t;
  item_t expq[$];

  always #10 clk = ~clk;

  intr_sequencer u_intr_sequencer (
    .clk(clk), .rst(rst), .irq_pend(irq_pend), .trap_req(trap_req),
    .instr_end(instr_end), .iret_req(iret_req), .i_bit(i_bit),
    .stk_valid(stk_valid), .stk_push(stk_push), .stk_reg(stk_reg),
    .stk_ready(stk_ready), .vec_valid(vec_valid), .vec_addr(vec_addr),
    .mask_wr(mask_wr), .mask_val(mask_val), .ack_valid(ack_valid),
    .ack_id(ack_id), .busy(busy), .wake_wait(wake_wait), .wake_halt(wake_halt)
  );

  // stack port with periodic stalls
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2 stk_ready = ((cyc % 3) != 1);
  end

  // CPU-side model: mask bit and edge-latched request clearing
  always @(posedge clk) begin
    if (mask_wr) i_bit <= mask_val;
    if (ack_valid) irq_pend[int'(ack_id) - 1] <= 1'b0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_entry(input int id, input string req);
    for (int k = 0; k < 5; k++) expq.push_back('{0, 8 + k, id, "R3"});
    expq.push_back('{1, 16'hFFFC - 2 * id, id, req});
  endtask

  task automatic expect_return();
    for (int k = 4; k >= 0; k--) expq.push_back('{0, k, 0, "R8"});
    expq.push_back('{2, 0, 0, "R9"});
  endtask

  task automatic take_item(input int kind, input int val, input int id);
    item_t it;
    if (expq.size() == 0) begin
      check(1'b0, "R2", kind, -1);
      return;
    end
    it = expq.pop_front();
    check(it.kind == kind && it.val == val, it.req, val, it.val);
    if (kind == 1) begin
      check(mask_wr && mask_val, "R4", {mask_wr, mask_val}, 3);
      if (it.id == 0) check(!ack_valid, "R10", ack_valid, 0);
      else check(ack_valid && int'(ack_id) == it.id, "R10", int'(ack_id), it.id);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (stk_valid && stk_ready) take_item(0, {stk_push, stk_reg}, 0);
      if (vec_valid) take_item(1, vec_addr, 0);
      if (mask_wr && !mask_val) take_item(2, 0, 0);
    end
  end

  task automatic pulse_end();
    @(posedge clk); #1 instr_end = 1'b1;
    @(posedge clk); #1 instr_end = 1'b0;
  endtask

  task automatic pulse_trap();
    @(posedge clk); #1 trap_req = 1'b1;
    @(posedge clk); #1 trap_req = 1'b0;
  endtask

  task automatic wait_idle();
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (!busy) return;
    end
    check(1'b0, "R3", busy, 0);
  endtask

  task automatic do_iret();
    expect_return();
    @(posedge clk); #1 iret_req = 1'b1;
    @(posedge clk); #1 iret_req = 1'b0;
    wait_idle();
    check(i_bit == 1'b0, "R9", i_bit, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!stk_valid && !vec_valid && !mask_wr && !ack_valid && !busy, "R12",
          {stk_valid, vec_valid, mask_wr, ack_valid, busy}, 0);
    check(!wake_wait && !wake_halt, "R12", {wake_wait, wake_halt}, 0);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!busy && !stk_valid, "R12", busy, 0);

    // single source entry, then check busy rises one cycle after boundary
    irq_pend = 4'b0100;
    expect_entry(3, "R4");
    @(posedge clk); #1 instr_end = 1'b1;
    @(negedge clk);
    check(!stk_valid, "R2", stk_valid, 0);
    @(posedge clk); #1 instr_end = 1'b0;
    @(negedge clk);
    check(stk_valid, "R2", stk_valid, 1);
    wait_idle();
    check(i_bit == 1'b1, "R4", i_bit, 1);

    // masked request stays pending across boundaries
    irq_pend[0] = 1'b1;
    for (int k = 0; k < 3; k++) begin
      pulse_end();
      @(negedge clk);
      check(!busy, "R1", busy, 0);
    end
    @(negedge clk);
    check(wake_wait && wake_halt, "R11", {wake_wait, wake_halt}, 3);
    #1 irq_pend = 4'b0010;
    @(negedge clk); @(negedge clk);
    check(wake_wait && !wake_halt, "R11", {wake_wait, wake_halt}, 2);
    #1 irq_pend = 4'b0001;
    do_iret();
    expect_entry(1, "R1");
    pulse_end();
    wait_idle();
    do_iret();

    // two sources at once: lower index first
    irq_pend = 4'b1010;
    expect_entry(2, "R6");
    pulse_end();
    wait_idle();
    check(irq_pend == 4'b1000, "R6", irq_pend, 4'b1000);
    do_iret();
    expect_entry(4, "R6");
    pulse_end();
    wait_idle();
    do_iret();

    // trap while masked, remembered until boundary; nested trap held
    i_bit = 1'b1;
    pulse_trap();
    @(negedge clk);
    check(!busy, "R5", busy, 0);
    expect_entry(0, "R5");
    pulse_end();
    pulse_trap();
    wait_idle();
    expect_entry(0, "R7");
    pulse_end();
    wait_idle();
    do_iret();
    do_iret();

    // trap and maskable source at the same boundary
    irq_pend = 4'b0001;
    expect_entry(0, "R5");
    @(posedge clk); #1 begin trap_req = 1'b1; instr_end = 1'b1; end
    @(posedge clk); #1 begin trap_req = 1'b0; instr_end = 1'b0; end
    wait_idle();
    check(irq_pend == 4'b0001, "R5", irq_pend, 1);
    do_iret();
    expect_entry(1, "R5");
    pulse_end();
    wait_idle();
    do_iret();

    repeat (4) @(negedge clk);
    check(expq.size() == 0, "R3", expq.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R2 watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule